// File: doc/BRIEF.md
# Nine-Pin GPIO Data Register

This block holds the output data of a nine-pin general-purpose port behind a 16-bit register word. Software writes the word with a one-cycle write strobe. The low nine bits land in a data latch, and the upper seven bits are discarded. Each pin has its own 2-bit mode code, which is supplied from outside. That code decides two things for the pin: whether the latch drives the pin, and whether a read of that bit returns the latch or the pin level.

Pin levels come in through a two-stage synchronizer before they reach the read path. The latch is cleared only by the power-on reset. A manual reset clears the synchronizer but leaves the latch intact. A stopped clock during sleep or standby has the same effect, because the latch simply holds its value.

Top module: `gpio_data_port`

## Requirements
- R1: After power-on reset (`por_n` low) all nine latch bits are 0, so a read with every pin in mode 01 returns 16'h0000.
- R2: A manual reset (`mrst_n` low) leaves the latch unchanged.
- R3: Read bits 15 to 9 are always 0, and write data in bits 15 to 9 has no effect.
- R4: In mode 00 (input), read bit n returns the level of `pin_in[n]` two clock edges after that level is applied.
- R5: In mode 01 (output), read bit n returns latch bit n, `pin_oe[n]` is 1 and `pin_out[n]` equals latch bit n.
- R6: In mode 10 (reserved), read bit n returns the synchronized pin level and `pin_oe[n]` is 0.
- R7: In mode 11 (alternate function), read bit n returns the synchronized pin level, `pin_oe[n]` is 0 and `pin_out[n]` is 0.
- R8: A write updates the latch bits in every mode, including modes in which the pin is not driven.
- R9: The mode of one pin has no effect on the read, drive or enable of any other pin. Pin n uses `mode[2n+1:2n]`.
- R10: Data written at a clock edge appears on `pin_out` and in the read data directly after that edge.
- R11: With the write strobe low, the latch holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears latch and synchronizer |
| mrst_n | input | 1 | Manual reset, synchronous, active low; clears synchronizer only |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 16 | Register write word |
| mode | input | 18 | Per-pin 2-bit mode, pin n at bits 2n+1:2n |
| rd_data | output | 16 | Mode-dependent read word |
| pin_in | input | 9 | Raw pin levels |
| pin_out | output | 9 | Pin drive values |
| pin_oe | output | 9 | Pin output enables |

## Verification
The read path and the pin drive are combinational from mode and state. A mode change therefore shows at once, and a write shows right after the edge that captures it. A pin level shows in the read data only after the second edge, because it passes through the synchronizer. Each vector in the bench drives its inputs at a falling edge and lets two rising edges pass before it samples at a falling edge. Directed tests sample after exactly one edge and after two edges to pin down the write latency and the input latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_IN   = 2'b00,
    PM_OUT  = 2'b01,
    PM_RSVD = 2'b10,
    PM_ALT  = 2'b11
  } pin_mode_e;

  // Only the output mode lets the latch reach the pin and the read path.
  function automatic logic mode_drives(input logic [1:0] m);
    return m == PM_OUT;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else if (!mrst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= raw_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign synced = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_data_latch.sv
module gpio_data_latch #(
  parameter int NPINS = 9
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wr_bits,
  output logic [NPINS-1:0] latch_q
);

  // Power-on reset only: manual reset and gated clocks leave contents alone.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     latch_q <= '0;
    else if (wr_en) latch_q <= wr_bits;
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 9,
  parameter int BUS_W = 16
) (
  input  logic [2*NPINS-1:0] mode,
  input  logic [NPINS-1:0]   latch_q,
  input  logic [NPINS-1:0]   pin_sync,
  output logic [BUS_W-1:0]   rd_data,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe
);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic drv;
    assign drv        = mode_drives(mode[2*n +: 2]);
    assign pin_oe[n]  = drv;
    assign pin_out[n] = drv & latch_q[n];
    assign rd_data[n] = drv ? latch_q[n] : pin_sync[n];
  end

  if (BUS_W > NPINS) begin : g_rsvd
    assign rd_data[BUS_W-1:NPINS] = '0;
  end

endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port #(
  parameter int NPINS       = 9,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               mrst_n,
  input  logic               wr_en,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [2*NPINS-1:0] mode,
  output logic [BUS_W-1:0]   rd_data,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe
);

  localparam int RSVD_W = BUS_W - NPINS;

  // Named internal wires, brought out for the checker.
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] wr_bits;
  logic             rsvd_wr_unused;

  assign wr_bits        = wr_data[NPINS-1:0];
  assign rsvd_wr_unused = (RSVD_W > 0) ? |wr_data[BUS_W-1:NPINS] : 1'b0;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .mrst_n (mrst_n),
    .raw_in (pin_in),
    .synced (pin_sync)
  );

  gpio_data_latch #(.NPINS(NPINS)) u_latch (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (wr_en),
    .wr_bits (wr_bits),
    .latch_q (latch_q)
  );

  gpio_pin_mux #(.NPINS(NPINS), .BUS_W(BUS_W)) u_mux (
    .mode     (mode),
    .latch_q  (latch_q),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

endmodule

// File: rtl/gpio_data_port_chk.sv
module gpio_data_port_chk #(
  parameter int NPINS = 9,
  parameter int BUS_W = 16
) (
  input logic               clk,
  input logic               por_n,
  input logic               mrst_n,
  input logic               wr_en,
  input logic [BUS_W-1:0]   wr_data,
  input logic [2*NPINS-1:0] mode,
  input logic [BUS_W-1:0]   rd_data,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pin_oe,
  input logic [NPINS-1:0]   latch_q,
  input logic [NPINS-1:0]   pin_sync
);

  a_r3_rsvd_read_zero: assert property (@(posedge clk) disable iff (!por_n)
    rd_data[BUS_W-1:NPINS] == '0);

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> latch_q == $past(wr_data[NPINS-1:0]));

  a_r11_hold_no_write: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(latch_q));

  a_r2_mrst_keeps_latch: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !wr_en) |=> $stable(latch_q));

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    a_r5_driven_read_matches_pin: assert property (@(posedge clk) disable iff (!por_n)
      pin_oe[n] |-> (rd_data[n] == pin_out[n] && pin_out[n] == latch_q[n]));

    a_r7_undriven_low: assert property (@(posedge clk) disable iff (!por_n)
      !pin_oe[n] |-> (!pin_out[n] && rd_data[n] == pin_sync[n]));

    a_r6_rsvd_mode_reads_pin: assert property (@(posedge clk) disable iff (!por_n)
      (mode[2*n +: 2] == 2'b10) |-> (!pin_oe[n] && rd_data[n] == pin_sync[n]));
  end

endmodule

bind gpio_data_port gpio_data_port_chk #(.NPINS(NPINS), .BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .mrst_n   (mrst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .mode     (mode),
  .rd_data  (rd_data),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .latch_q  (latch_q),
  .pin_sync (pin_sync)
);

// File: tb/test_gpio_data_port.sv
module test_gpio_data_port;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 9;
  localparam int BW = 16;

  localparam logic [17:0] M_IN  = 18'h00000;
  localparam logic [17:0] M_OUT = 18'h15555;
  localparam logic [17:0] M_RSV = 18'h2AAAA;
  localparam logic [17:0] M_ALT = 18'h3FFFF;
  localparam logic [17:0] M_MIX = 18'h0E4E4;  // pins 0..8: 00,01,10,11,00,01,10,11,00

  typedef struct packed {
    logic [17:0] md;
    logic [15:0] wd;
    logic [8:0]  pin;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{M_OUT, 16'hFE5A, 9'h0F0},
    '{M_IN,  16'h0123, 9'h1A5},
    '{M_RSV, 16'h01FF, 9'h055},
    '{M_ALT, 16'h00AA, 9'h133},
    '{M_MIX, 16'h01FF, 9'h000},
    '{M_MIX, 16'h0000, 9'h1FF},
    '{M_MIX, 16'h8155, 9'h0AA}
  };

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          mrst_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [BW-1:0] wr_data = '0;
  logic [17:0]   mode = '0;
  logic [BW-1:0] rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_data_port i_gpio_data_port (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en),
    .wr_data(wr_data), .mode(mode), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic logic [15:0] exp_rd(input logic [17:0] m, input logic [8:0] lat, input logic [8:0] p);
    logic [15:0] r = '0;
    for (int n = 0; n < NP; n++) r[n] = (m[2*n +: 2] == 2'b01) ? lat[n] : p[n];
    return r;
  endfunction

  function automatic logic [8:0] exp_oe(input logic [17:0] m);
    logic [8:0] r = '0;
    for (int n = 0; n < NP; n++) r[n] = (m[2*n +: 2] == 2'b01);
    return r;
  endfunction

  task automatic write_word(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: power-on reset state
    repeat (3) @(negedge clk);
    por_n = 1'b1; mode = M_OUT;
    @(negedge clk);
    check("R1 rd after por", rd_data, 16'h0000);
    check("R1 pin_out after por", {7'd0, pin_out}, 16'h0000);

    // Vector table: R5 R6 R7 R8 R9 R3
    for (int v = 0; v < NV; v++) begin
      logic [8:0] lat;
      @(negedge clk);
      mode = VECS[v].md; pin_in = VECS[v].pin;
      wr_en = 1'b1; wr_data = VECS[v].wd;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
      lat = VECS[v].wd[8:0];
      check($sformatf("R5/R6/R7/R9 rd vec%0d", v), rd_data, exp_rd(VECS[v].md, lat, VECS[v].pin));
      check($sformatf("R5/R7 pin_out vec%0d", v), {7'd0, pin_out}, {7'd0, exp_oe(VECS[v].md) & lat});
      check($sformatf("R6/R9 pin_oe vec%0d", v), {7'd0, pin_oe}, {7'd0, exp_oe(VECS[v].md)});
      mode = M_OUT;
      #1;
      check($sformatf("R8 latch via out mode vec%0d", v), rd_data, {7'd0, lat});
    end

    // R3: reserved write bits ignored
    mode = M_OUT;
    write_word(16'hFE00);
    check("R3 rsvd write ignored", rd_data, 16'h0000);

    // R10: write visible right after capturing edge
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0136;
    @(posedge clk); #1; wr_en = 1'b0;
    check("R10 rd one edge after write", rd_data, 16'h0136);
    check("R10 pin_out one edge after write", {7'd0, pin_out}, 16'h0136);

    // R11: latch holds across idle cycles with changing wr_data
    @(negedge clk); wr_data = 16'h00C9;
    repeat (4) @(negedge clk);
    check("R11 hold without strobe", rd_data, 16'h0136);

    // R2: manual reset keeps latch
    mrst_n = 1'b0;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    @(negedge clk);
    check("R2 latch after manual reset", rd_data, 16'h0136);

    // R4: two-edge input latency
    mode = M_IN; pin_in = 9'h000;
    repeat (3) @(negedge clk);
    check("R4 input baseline", rd_data, 16'h0000);
    pin_in = 9'h155;
    @(negedge clk);
    check("R4 one edge not yet", rd_data, 16'h0000);
    @(negedge clk);
    check("R4 two edges seen", rd_data, 16'h0155);

    // R1: power-on reset clears latch written earlier
    mode = M_OUT;
    por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    check("R1 por clears latch", rd_data, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule